// File: doc/BRIEF.md
# Grouped Carry-Skip Binary Adder

This block adds two unsigned operands and an incoming carry, producing a sum of the same width and a carry output. The operand width is cut into equal groups. Inside a group the carry ripples from bit to bit. Each group also has a skip multiplexer. When every bit of the group propagates, the multiplexer sends the group's incoming carry straight to the next group, and the rippled chain is not used for the carry out.

Each bit falls into exactly one of three classes: generate, propagate or kill. A carry that crosses a group therefore waits only for one multiplexer, and not for a ripple through the group. The slowest path is a generate or kill at bit 0 with every other bit propagating. That path ripples out of the first group, skips through the middle groups, and ripples into the top sum bit of the last group.

The delay grows with the number of groups and not with the width. A per-group skip flag is brought out for debug. An optional output register lets the adder sit between flops for timing runs. The block has no state machine, so no states or transitions exist.

Top module: `cba_adder`

## Requirements
- R1: For every input, `{carry_out, sum}` equals `op_a + op_b + carry_in`, computed at WIDTH+1 bits.
- R2: `group_skip[j]` is 1 exactly when `op_a ^ op_b` is all ones over bits j*GROUP_BITS to j*GROUP_BITS+GROUP_BITS-1. Group 0 holds the least significant bits.
- R3: Each bit is classified in exactly one way. It is generate when both operand bits are 1, propagate when they differ, and kill when both are 0. A group that holds any generate or kill bit reports skip 0, so operands with `op_a == op_b` give `group_skip` all zero.
- R4: A group whose skip is 1 forwards its incoming carry unchanged to its carry output. With `op_b == ~op_a`, a carry-in of 0 gives an all-ones sum and carry_out 0. A carry-in of 1 gives a zero sum and carry_out 1.
- R5: `carry_out` is the carry output of the most significant group. Take the worst-case pattern: bit 0 generates, every other bit propagates, and carry-in is 0. It gives a zero sum, carry_out 1, and skip set on every group except group 0.
- R6: The adder has WIDTH/GROUP_BITS groups, each with one skip bit. Elaboration fails for a GROUP_BITS below 1, or for a WIDTH that is not an exact multiple of GROUP_BITS.
- R7: With REGISTER_OUT = 0, all outputs follow the inputs with no clock. With REGISTER_OUT = 1, `sum`, `carry_out` and `group_skip` show the result of the operands present at the previous rising clock edge. An active-low asynchronous reset clears these registered outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry at bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry from the most significant group |
| group_skip | output | WIDTH/GROUP_BITS | Per-group flag, 1 when the group took its skip path |

## Verification
The clocked checks assume that the operands and the carry-in are stable at each rising clock edge. In the combinational build, they also assume the sum has settled by that edge. The bench changes inputs only on falling edges, or a step after one, so every rising edge sees quiet inputs. After reset the registered check compares outputs with the inputs of the prior edge. The bench therefore holds reset across at least one edge and starts driving only after it is released.

// File: rtl/cba_pkg.sv
package cba_pkg;

    // Class of one bit position; exactly one member is set.
    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } bit_class_t;

endpackage

// File: rtl/cba_bit_cell.sv
module cba_bit_cell
    import cba_pkg::*;
(
    input  logic       in_a,
    input  logic       in_b,
    output bit_class_t cls
);

    always_comb begin
        cls.gen  = in_a & in_b;
        cls.prop = in_a ^ in_b;
        cls.kill = ~in_a & ~in_b;
    end

endmodule

// File: rtl/cba_group.sv
module cba_group
    import cba_pkg::*;
#(
    parameter int BITS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] grp_a,
    input  logic [BITS-1:0] grp_b,
    input  logic            grp_cin,
    output logic [BITS-1:0] grp_sum,
    output logic            grp_cout,
    output logic            grp_skip
);

    bit_class_t      cls [BITS];
    logic [BITS:0]   rc;
    logic [BITS-1:0] pvec;
    logic [BITS-1:0] blockers;

    assign rc[0] = grp_cin;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        cba_bit_cell u_cell (
            .in_a (grp_a[i]),
            .in_b (grp_b[i]),
            .cls  (cls[i])
        );

        assign rc[i+1]     = cls[i].gen | (cls[i].prop & rc[i]);
        assign grp_sum[i]  = cls[i].prop ^ rc[i];
        assign pvec[i]     = cls[i].prop;
        assign blockers[i] = cls[i].gen | cls[i].kill;

        // R3: one class per bit
        assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot({cls[i].gen, cls[i].prop, cls[i].kill}));
    end

    // Skip multiplexer: all-propagate group forwards its carry-in.
    assign grp_skip = &pvec;
    assign grp_cout = grp_skip ? grp_cin : rc[BITS];

    // R4: bypass forwards carry-in
    assert_bypass_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grp_skip |-> (grp_cout == grp_cin));

    // R4: rippled chain agrees with the bypass when skipping
    assert_ripple_agrees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grp_skip |-> (rc[BITS] == grp_cin));

    // R3: a non-skipping group holds a generate or kill bit
    assert_skip_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_skip |-> (blockers != '0));

endmodule

// File: rtl/cba_adder.sv
module cba_adder #(
    parameter int WIDTH        = 20,
    parameter int GROUP_BITS   = 5,
    parameter bit REGISTER_OUT = 1'b0
) (
    input  logic                                                    clk,
    input  logic                                                    rst_n,
    input  logic [WIDTH-1:0]                                        op_a,
    input  logic [WIDTH-1:0]                                        op_b,
    input  logic                                                    carry_in,
    output logic [WIDTH-1:0]                                        sum,
    output logic                                                    carry_out,
    output logic [((GROUP_BITS >= 1) ? WIDTH / GROUP_BITS : 1)-1:0] group_skip
);

    localparam int GROUPS = (GROUP_BITS >= 1) ? WIDTH / GROUP_BITS : 1;
    localparam int OUT_W  = GROUPS + 1 + WIDTH;

    // R6: parameter checks at elaboration
    if (GROUP_BITS < 1) begin : g_bad_k
        $error("cba_adder: GROUP_BITS must be at least 1");
    end else if ((WIDTH % GROUP_BITS) != 0) begin : g_bad_split
        $error("cba_adder: WIDTH must be a multiple of GROUP_BITS");
    end

    logic [GROUPS:0]      chain;
    logic [WIDTH-1:0]     raw_sum;
    logic [GROUPS-1:0]    raw_skip;
    logic [OUT_W-1:0]     out_d;
    logic [OUT_W-1:0]     out_q;

    assign chain[0] = carry_in;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        cba_group #(.BITS(GROUP_BITS)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .grp_a    (op_a[g*GROUP_BITS +: GROUP_BITS]),
            .grp_b    (op_b[g*GROUP_BITS +: GROUP_BITS]),
            .grp_cin  (chain[g]),
            .grp_sum  (raw_sum[g*GROUP_BITS +: GROUP_BITS]),
            .grp_cout (chain[g+1]),
            .grp_skip (raw_skip[g])
        );
    end

    assign out_d = {raw_skip, chain[GROUPS], raw_sum};

    if (REGISTER_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign sum        = out_q[WIDTH-1:0];
    assign carry_out  = out_q[WIDTH];
    assign group_skip = out_q[OUT_W-1:WIDTH+1];

    if (REGISTER_OUT) begin : g_chk_reg
        // R7 and R1: registered result one edge later
        assert_sum_delayed_R7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ({carry_out, sum} ==
                      $past({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})));
    end else begin : g_chk_comb
        // R1: total matches the arithmetic sum
        assert_sum_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
            {carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
    end

endmodule

// File: tb/test_cba_adder.sv
module test_cba_adder;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 20;
    localparam int K  = 5;
    localparam int NG = W / K;
    localparam int SW = 4;
    localparam int SK = 2;
    localparam int SG = SW / SK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [NG-1:0] sk;

    logic [SW-1:0] sa, sb, ss;
    logic          sci, sco;
    logic [SG-1:0] ssk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cba_adder #(.WIDTH(W), .GROUP_BITS(K), .REGISTER_OUT(1'b0)) i_cba_adder (
        .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .carry_in(ci),
        .sum(s), .carry_out(co), .group_skip(sk));

    cba_adder #(.WIDTH(SW), .GROUP_BITS(SK), .REGISTER_OUT(1'b1)) i_cba_adder_small (
        .clk(clk), .rst_n(rst_n), .op_a(sa), .op_b(sb), .carry_in(sci),
        .sum(ss), .carry_out(sco), .group_skip(ssk));

    function automatic logic [NG-1:0] skip_w(logic [W-1:0] x, logic [W-1:0] y);
        logic [NG-1:0] r;
        logic [W-1:0]  p;
        p = x ^ y;
        for (int j = 0; j < NG; j++) r[j] = &p[j*K +: K];
        return r;
    endfunction

    function automatic logic [SG-1:0] skip_s(logic [SW-1:0] x, logic [SW-1:0] y);
        logic [SG-1:0] r;
        logic [SW-1:0] p;
        p = x ^ y;
        for (int j = 0; j < SG; j++) r[j] = &p[j*SK +: SK];
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational wide instance: drive, settle, compare.
    task automatic apply_w(logic [W-1:0] x, logic [W-1:0] y, logic c, string req);
        logic [W:0] e;
        @(negedge clk);
        a = x; b = y; ci = c;
        #1;
        e = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        check({req, " R1 total"}, 64'({co, s}), 64'(e));
        check({req, " R2 skip"}, 64'(sk), 64'(skip_w(x, y)));
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        sa = '0; sb = '0; sci = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R7: reset clears registered outputs
        check("R7 reset", 64'({ssk, sco, ss}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: group count and skip width
        check("R6 groups", 64'($bits(sk)), 64'd4);

        // R1 R2 R7: exhaustive registered small adder
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [SW:0] e;
                    sa = SW'(x); sb = SW'(y); sci = c[0];
                    e = 5'(x) + 5'(y) + 5'(c);
                    @(negedge clk);
                    check("R7 R1 small total", 64'({sco, ss}), 64'(e));
                    check("R7 R2 small skip", 64'(ssk), 64'(skip_s(SW'(x), SW'(y))));
                end
            end
        end

        // R4: every group propagating, both carry-ins
        begin
            logic [W-1:0] x;
            x = W'($urandom(32'd1234));
            apply_w(x, ~x, 1'b0, "R4 allprop c0");
            check("R4 allprop c0 sum", 64'(s), 64'({W{1'b1}}));
            check("R4 allprop c0 cout", 64'(co), 64'd0);
            apply_w(x, ~x, 1'b1, "R4 allprop c1");
            check("R4 allprop c1 sum", 64'(s), 64'd0);
            check("R4 allprop c1 cout", 64'(co), 64'd1);
        end

        // R5: worst-case path pattern
        begin
            logic [W-1:0] x, y;
            x = W'($urandom()) | W'(1);
            y = (~x) | W'(1);
            apply_w(x, y, 1'b0, "R5 worst");
            check("R5 worst sum", 64'(s), 64'd0);
            check("R5 worst cout", 64'(co), 64'd1);
            check("R5 worst skip", 64'(sk), 64'(4'b1110));
        end

        // R3: equal operands hold only generate or kill bits
        begin
            logic [W-1:0] x;
            x = W'($urandom());
            apply_w(x, x, 1'b1, "R3 equal");
            check("R3 equal skip", 64'(sk), 64'd0);
        end

        // R2 R4: one group all-propagate in turn
        for (int g = 0; g < NG; g++) begin
            for (int n = 0; n < 8; n++) begin
                logic [W-1:0] x, y;
                x = W'($urandom());
                y = W'($urandom());
                y[g*K +: K] = ~x[g*K +: K];
                apply_w(x, y, n[0], "R2 R4 one group");
            end
        end

        // R1: random wide vectors
        for (int n = 0; n < 2000; n++) begin
            apply_w(W'($urandom()), W'($urandom()), 1'($urandom()), "R1 random");
        end

        // R1: extremes
        apply_w('0, '0, 1'b0, "R1 zero");
        apply_w({W{1'b1}}, {W{1'b1}}, 1'b1, "R1 max");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule